// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns an instruction's addressing-mode code, register specifiers and 16-bit offset field into the operand's effective address. It holds its own file of general registers. For the auto-increment and auto-decrement modes it also updates the base register, so a stream of instructions walking through memory sees each pointer move in step. One computation is accepted per cycle through a valid/ready pair. The result is registered and appears on the cycle after acceptance.

The unit supports these modes:
- register-direct, which passes the register's value through for observation;
- offset plus base;
- offset plus base plus index;
- immediate, which carries the sign-extended offset field as the operand value;
- post-increment;
- pre-decrement.

Two codes are reserved and are reported as illegal. A separate write port lets the rest of the pipeline load registers.

Top module: `opnd_addr_unit`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1 and all eight registers read as 0.
- R2: An input is accepted on a clock edge where `inValid` and `inReady` are both 1, and its result appears with `outValid`=1 from the next cycle. `inReady` is 1 exactly when `outValid` is 0 or `outReady` is 1. While `outValid`=1 and `outReady`=0, all outputs hold.
- R3: Mode code 0 (register-direct) gives `outAddr` = [Ri] with `outRegDir`=1. It makes no register update.
- R4: Mode code 1 (indexed) gives `outAddr` = sext(offset) + [Ri]. For example, Ri=1200 with offset 20 gives 1220, and a negative offset subtracts.
- R5: Mode code 2 (base plus index plus offset) gives `outAddr` = sext(offset) + [Ri] + [Rj]. For example, 1200 + 4600 + 30 gives 5830.
- R6: Mode code 3 (immediate) gives `outImm`=1 and puts the sign-extended offset field on `outAddr`. It makes no register update.
- R7: Mode code 4 (post-increment) gives `outAddr` = [Ri] and writes [Ri]+step into Ri. It reports `outUpdEn`=1, `outUpdIdx`=Ri and `outUpdVal` equal to the new value.
- R8: Mode code 5 (pre-decrement) writes [Ri]-step into Ri and uses that value as `outAddr`. It reports the update the same way as R7. For example, Ri=4600 with a byte step gives 4599.
- R9: The step is 4 when `inWord`=1 and 1 when `inWord`=0.
- R10: Mode codes 6 and 7 give `outIllegal`=1 and `outAddr`=0. They make no register update.
- R11: All address and pointer arithmetic wraps modulo 2^32.
- R12: `wrEn` writes `wrData` into register `wrIdx` at the clock edge. If an accepted auto-mode instruction updates the same register at the same edge, the auto-mode value wins.
- R13: The auto-mode register update lands on the accepting edge, so an instruction accepted on the next cycle reads the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Unit can accept a request |
| inMode | input | 3 | Addressing-mode code |
| inWord | input | 1 | Operand size: 1 = 4-byte word, 0 = byte |
| inRi | input | 3 | Base register specifier |
| inRj | input | 3 | Index register specifier |
| inOffset | input | 16 | Signed offset or immediate field |
| wrEn | input | 1 | External register write enable |
| wrIdx | input | 3 | External write register index |
| wrData | input | 32 | External write data |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outAddr | output | 32 | Effective address, immediate value or register value |
| outImm | output | 1 | Operand is immediate, no memory access |
| outRegDir | output | 1 | Operand is a register, no memory access |
| outIllegal | output | 1 | Reserved mode code was presented |
| outUpdEn | output | 1 | A register was updated by this instruction |
| outUpdIdx | output | 3 | Index of the updated register |
| outUpdVal | output | 32 | New value of the updated register |

## Verification
A wrong value written into the register file shows at the ports only when that register is next read. This happens at the next request that names the register, one cycle after it is accepted. For that reason the bench re-reads each pointer through register-direct mode soon after it moves. A lost or doubled auto-mode update appears as an address off by one step on the following access. A mis-timed write-back appears at once in a back-to-back chain on one register. A broken valid/ready state shows in the same cycle as a wrong `inReady`, or as an output that changes during a stall.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam logic [2:0] MODE_REG = 3'd0;
  localparam logic [2:0] MODE_IDX = 3'd1;
  localparam logic [2:0] MODE_BIX = 3'd2;
  localparam logic [2:0] MODE_IMM = 3'd3;
  localparam logic [2:0] MODE_INC = 3'd4;
  localparam logic [2:0] MODE_DEC = 3'd5;

  typedef struct packed {
    logic accept;
    logic useIdx;
    logic useOff;
    logic immSel;
    logic regSel;
    logic preDec;
    logic postInc;
    logic illegal;
  } oauStrobes_t;
endpackage

// File: rtl/oau_regfile.sv
module oau_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rdIdxA,
  input  logic [IDXW-1:0] rdIdxB,
  output logic [DW-1:0]   rdValA,
  output logic [DW-1:0]   rdValB,
  input  logic            updEn,
  input  logic [IDXW-1:0] updIdx,
  input  logic [DW-1:0]   updVal,
  input  logic            extEn,
  input  logic [IDXW-1:0] extIdx,
  input  logic [DW-1:0]   extVal
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (updEn && updIdx == IDXW'(i)) regs[i] <= updVal;
      else if (extEn && extIdx == IDXW'(i)) regs[i] <= extVal;
    end
  end

  assign rdValA = regs[rdIdxA];
  assign rdValB = regs[rdIdxB];
endmodule

// File: rtl/oau_ctrl.sv
module oau_ctrl
  import oau_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  input  logic [2:0]  inMode,
  input  logic        outReady,
  output logic        outValid,
  output oauStrobes_t strb
);
  logic validQ;
  logic accept;

  assign inReady  = !validQ || outReady;
  assign accept   = inValid && inReady;
  assign outValid = validQ;

  always_ff @(posedge clk) begin
    if (rst)           validQ <= 1'b0;
    else if (accept)   validQ <= 1'b1;
    else if (outReady) validQ <= 1'b0;
  end

  always_comb begin
    strb        = '0;
    strb.accept = accept;
    case (inMode)
      MODE_REG: strb.regSel  = 1'b1;
      MODE_IDX: strb.useOff  = 1'b1;
      MODE_BIX: begin
        strb.useOff = 1'b1;
        strb.useIdx = 1'b1;
      end
      MODE_IMM: strb.immSel  = 1'b1;
      MODE_INC: strb.postInc = 1'b1;
      MODE_DEC: strb.preDec  = 1'b1;
      default:  strb.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/oau_datapath.sv
module oau_datapath
  import oau_pkg::*;
#(
  parameter int DW   = 32,
  parameter int OFFW = 16,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  oauStrobes_t     strb,
  input  logic            word,
  input  logic [IDXW-1:0] riIdx,
  input  logic [DW-1:0]   riVal,
  input  logic [DW-1:0]   rjVal,
  input  logic [OFFW-1:0] offset,
  output logic            wbEn,
  output logic [DW-1:0]   wbVal,
  output logic [DW-1:0]   outAddr,
  output logic            outImm,
  output logic            outRegDir,
  output logic            outIllegal,
  output logic            outUpdEn,
  output logic [IDXW-1:0] outUpdIdx,
  output logic [DW-1:0]   outUpdVal
);
  localparam int WORD_BYTES = 4;

  logic [DW-1:0] step, sext, sum, incVal, decVal, nextAddr;
  logic          autoMode;

  assign step     = word ? DW'(WORD_BYTES) : DW'(1);
  assign sext     = {{(DW-OFFW){offset[OFFW-1]}}, offset};
  assign sum      = riVal + (strb.useIdx ? rjVal : '0) + (strb.useOff ? sext : '0);
  assign incVal   = riVal + step;
  assign decVal   = riVal - step;
  assign autoMode = strb.preDec || strb.postInc;

  always_comb begin
    if (strb.illegal)      nextAddr = '0;
    else if (strb.immSel)  nextAddr = sext;
    else if (strb.regSel)  nextAddr = riVal;
    else if (strb.preDec)  nextAddr = decVal;
    else if (strb.postInc) nextAddr = riVal;
    else                   nextAddr = sum;
  end

  assign wbEn  = strb.accept && autoMode;
  assign wbVal = strb.preDec ? decVal : incVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr    <= '0;
      outImm     <= 1'b0;
      outRegDir  <= 1'b0;
      outIllegal <= 1'b0;
      outUpdEn   <= 1'b0;
      outUpdIdx  <= '0;
      outUpdVal  <= '0;
    end else if (strb.accept) begin
      outAddr    <= nextAddr;
      outImm     <= strb.immSel;
      outRegDir  <= strb.regSel;
      outIllegal <= strb.illegal;
      outUpdEn   <= autoMode;
      outUpdIdx  <= riIdx;
      outUpdVal  <= autoMode ? wbVal : '0;
    end
  end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int OFFW = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic [2:0]      inMode,
  input  logic            inWord,
  input  logic [IDXW-1:0] inRi,
  input  logic [IDXW-1:0] inRj,
  input  logic [OFFW-1:0] inOffset,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [DW-1:0]   wrData,
  output logic            outValid,
  input  logic            outReady,
  output logic [DW-1:0]   outAddr,
  output logic            outImm,
  output logic            outRegDir,
  output logic            outIllegal,
  output logic            outUpdEn,
  output logic [IDXW-1:0] outUpdIdx,
  output logic [DW-1:0]   outUpdVal
);
  oauStrobes_t   strb;
  logic [DW-1:0] riVal, rjVal, wbVal;
  logic          wbEn;

  oau_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inMode(inMode), .outReady(outReady), .outValid(outValid), .strb(strb)
  );

  oau_regfile #(.DW(DW), .NREG(NREG), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst(rst), .rdIdxA(inRi), .rdIdxB(inRj),
    .rdValA(riVal), .rdValB(rjVal),
    .updEn(wbEn), .updIdx(inRi), .updVal(wbVal),
    .extEn(wrEn), .extIdx(wrIdx), .extVal(wrData)
  );

  oau_datapath #(.DW(DW), .OFFW(OFFW), .IDXW(IDXW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .word(inWord), .riIdx(inRi),
    .riVal(riVal), .rjVal(rjVal), .offset(inOffset),
    .wbEn(wbEn), .wbVal(wbVal),
    .outAddr(outAddr), .outImm(outImm), .outRegDir(outRegDir),
    .outIllegal(outIllegal), .outUpdEn(outUpdEn),
    .outUpdIdx(outUpdIdx), .outUpdVal(outUpdVal)
  );
endmodule

// File: rtl/opnd_addr_chk.sv
module opnd_addr_chk #(
  parameter int DW   = 32,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [DW-1:0]   outAddr,
  input logic            outImm,
  input logic            outRegDir,
  input logic            outIllegal,
  input logic            outUpdEn,
  input logic [DW-1:0]   outUpdVal
);
  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outUpdEn) && $stable(outUpdVal));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && outIllegal |-> !outUpdEn && outAddr == '0);

  // R6
  imm_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && outImm |-> !outUpdEn);

  // R3
  kind_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $onehot0({outImm, outRegDir, outIllegal, outUpdEn}));

  // R9
  step_relation_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && outUpdEn |->
      (outUpdVal == outAddr) || (outUpdVal - outAddr == DW'(1)) || (outUpdVal - outAddr == DW'(4)));
endmodule

bind opnd_addr_unit opnd_addr_chk #(.DW(DW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
  .outImm(outImm), .outRegDir(outRegDir), .outIllegal(outIllegal),
  .outUpdEn(outUpdEn), .outUpdVal(outUpdVal)
);

// File: tb/opnd_addr_unit_bench.sv
`timescale 1ns/1ps
module opnd_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0, inWord = 1'b0, wrEn = 1'b0, outReady = 1'b1;
  logic [2:0]  inMode = '0, inRi = '0, inRj = '0, wrIdx = '0;
  logic [15:0] inOffset = '0;
  logic [31:0] wrData = '0;
  logic        inReady, outValid, outImm, outRegDir, outIllegal, outUpdEn;
  logic [2:0]  outUpdIdx;
  logic [31:0] outAddr, outUpdVal;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opnd_addr_unit u_opnd_addr_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inMode(inMode), .inWord(inWord), .inRi(inRi), .inRj(inRj),
    .inOffset(inOffset), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outImm(outImm), .outRegDir(outRegDir), .outIllegal(outIllegal),
    .outUpdEn(outUpdEn), .outUpdIdx(outUpdIdx), .outUpdVal(outUpdVal)
  );

  // behavioural reference model
  logic [31:0] mRegs [8];
  bit          mValid = 0, mImm, mRegDir, mIll, mUpd, anyWrite = 0, lastUpd = 0;
  logic [2:0]  mUpdIdx, lastIdx;
  logic [31:0] mAddr, mUpdVal;
  string       mTag = "R2";

  always @(posedge clk) begin
    if (rst) begin
      mValid = 0; lastUpd = 0; anyWrite = 0;
      for (int i = 0; i < 8; i++) mRegs[i] = 0;
    end else begin
      bit acc;
      acc = inValid && (!mValid || outReady);
      if (acc) begin
        logic [31:0] a, b, off, st;
        a = mRegs[inRi]; b = mRegs[inRj];
        off = {{16{inOffset[15]}}, inOffset};
        st = inWord ? 32'd4 : 32'd1;
        mValid = 1; mImm = 0; mRegDir = 0; mIll = 0; mUpd = 0;
        mUpdIdx = inRi; mUpdVal = 0;
        case (inMode)
          3'd0: begin mAddr = a; mRegDir = 1; mTag = anyWrite ? "R3" : "R1/R3"; end
          3'd1: begin mAddr = a + off; mTag = "R4"; end
          3'd2: begin mAddr = a + b + off; mTag = "R5"; end
          3'd3: begin mAddr = off; mImm = 1; mTag = "R6"; end
          3'd4: begin
            mAddr = a; mUpd = 1; mUpdVal = a + st;
            mTag = (mUpdVal < a) ? "R7/R9/R11" : "R7/R9";
          end
          3'd5: begin
            mAddr = a - st; mUpd = 1; mUpdVal = a - st;
            mTag = (a < st) ? "R8/R9/R11" : "R8/R9";
          end
          default: begin mAddr = 0; mIll = 1; mTag = "R10"; end
        endcase
        if (lastUpd && lastIdx == inRi) mTag = {mTag, "/R13"};
        if (mUpd && wrEn && wrIdx == inRi) mTag = {mTag, "/R12"};
        lastUpd = mUpd; lastIdx = inRi;
      end else begin
        if (outReady) mValid = 0;
        if (inValid == 0) lastUpd = 0;
      end
      if (wrEn) begin mRegs[wrIdx] = wrData; anyWrite = 1; end
      if (acc && mUpd) mRegs[inRi] = mUpdVal;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", 32'(inReady), 32'(!mValid || outReady));
      chk("R2", 32'(outValid), 32'(mValid));
      if (mValid && outValid) begin
        chk(mTag, outAddr, mAddr);
        chk(mTag, {28'd0, outImm, outRegDir, outIllegal, outUpdEn},
                  {28'd0, mImm, mRegDir, mIll, mUpd});
        if (mUpd) begin
          chk(mTag, 32'(outUpdIdx), 32'(mUpdIdx));
          chk(mTag, outUpdVal, mUpdVal);
        end
      end
    end
  end

  task automatic send(input logic [2:0] m, input logic [2:0] ri, input logic [2:0] rj,
                      input logic [15:0] off, input logic w,
                      input logic we = 0, input logic [2:0] wi = 0, input logic [31:0] wd = 0);
    @(negedge clk); #1;
    inMode = m; inRi = ri; inRj = rj; inOffset = off; inWord = w; inValid = 1;
    wrEn = we; wrIdx = wi; wrData = wd;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 0; wrEn = 0;
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk); #1;
    wrEn = 1; wrIdx = idx; wrData = val;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    #400000;
    nChk++; nFail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle handshake state under reset
    chk("R1", 32'(outValid), 32'd0);
    chk("R1", 32'(inReady), 32'd1);
    #1 rst = 0;
    send(3'd0, 3'd6, 3'd0, 16'd0, 0);            // R1 register reads zero
    writeReg(3'd1, 32'd1200);
    writeReg(3'd2, 32'd4600);                     // R12 plain write
    send(3'd1, 3'd1, 3'd0, 16'd20, 0);            // R4 -> 1220
    send(3'd2, 3'd1, 3'd2, 16'd30, 0);            // R5 -> 5830
    send(3'd3, 3'd0, 3'd0, 16'd3000, 0);          // R6
    send(3'd3, 3'd0, 3'd0, 16'h8001, 1);          // R6 negative immediate
    send(3'd5, 3'd2, 3'd0, 16'd0, 0);             // R8 -> 4599
    send(3'd4, 3'd1, 3'd0, 16'd0, 1);             // R7 -> 1200, R1=1204
    send(3'd0, 3'd1, 3'd0, 16'd0, 0);             // R3 reads 1204
    send(3'd0, 3'd2, 3'd0, 16'd0, 0);             // R3 reads 4599
    send(3'd1, 3'd1, 3'd0, 16'hFFEC, 0);          // R4 negative offset -> 1184
    send(3'd6, 3'd1, 3'd0, 16'd5, 0);             // R10
    send(3'd7, 3'd2, 3'd0, 16'd5, 1);             // R10
    send(3'd0, 3'd1, 3'd0, 16'd0, 0);             // R10 left R1 alone
    writeReg(3'd3, 32'd0);
    send(3'd5, 3'd3, 3'd0, 16'd0, 1);             // R11 -> FFFFFFFC
    writeReg(3'd4, 32'hFFFF_FFFF);
    send(3'd4, 3'd4, 3'd0, 16'd0, 0);             // R11 -> R4 = 0
    send(3'd0, 3'd4, 3'd0, 16'd0, 0);
    send(3'd2, 3'd3, 3'd2, 16'h0010, 0);          // R11 base-index wrap
    writeReg(3'd5, 32'd100);
    send(3'd4, 3'd5, 3'd0, 16'd0, 1);             // R13 chain
    send(3'd4, 3'd5, 3'd0, 16'd0, 1);
    send(3'd5, 3'd5, 3'd0, 16'd0, 0);
    send(3'd0, 3'd5, 3'd0, 16'd0, 0);             // 107
    // R2 stall: consumer holds off for several cycles
    @(negedge clk); #1 outReady = 0;
    fork
      begin
        send(3'd1, 3'd2, 3'd0, 16'd1, 0);
        send(3'd2, 3'd1, 3'd2, 16'd2, 0);
      end
      begin
        repeat (5) @(negedge clk);
        #1 outReady = 1;
      end
    join
    // R12 collision: auto update beats the external write
    send(3'd4, 3'd6, 3'd0, 16'd0, 1, 1, 3'd6, 32'd500);
    send(3'd0, 3'd6, 3'd0, 16'd0, 0);             // expect 4
    send(3'd5, 3'd6, 3'd0, 16'd0, 1, 1, 3'd7, 32'd77);
    send(3'd0, 3'd6, 3'd0, 16'd0, 0);             // expect 0
    send(3'd0, 3'd7, 3'd0, 16'd0, 0);             // expect 77
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule